// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This unit holds the 11-bit fetch address of a small microcontroller core and works out where the address goes next. Each cycle it receives decoded control strobes from the instruction decoder: advance, jump, call, return and a write to the address low byte. It also receives the two page-select bits and the 9-bit target field of the current instruction. The next address is registered, so the value on `pc_o` is the address that is fetched in the following cycle.

A jump or call places the page bits above the 9-bit target, which gives four pages of 512 words each. A call also saves the address of the next instruction in an 8-level circular return stack, and a return restores the most recent saved address. The low byte of the address is also visible as a data register. Software can read it and can overwrite it. Overwriting it branches within the current 256-word block, which lets software build jump tables.

All pins are plain control or data signals. The unit has no streaming interface, so it exerts no back-pressure and needs none. A strobe takes effect on the clock edge where it is sampled high.

Top module: `pc_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `pc_o` reads 7FFh and the return stack is empty.
- R2: With only `step_i` high, `pc_o` increases by one per cycle and wraps from 7FFh to 000h.
- R3: A jump loads `pc_o` with `{page_i, target_i}`: bits 10:9 from the page and bits 8:0 from the target.
- R4: A call loads the same address as a jump and pushes `pc_o + 1` (wrapping) onto the return stack.
- R5: A return loads `pc_o` with the most recently pushed entry that has not been popped, in last-in-first-out order.
- R6: A low-byte write loads `{pc_o[10:8], low_wdata_i}`. `low_rdata_o` always equals `pc_o[7:0]`.
- R7: The stack holds 8 entries. A ninth push without a pop discards the oldest entry, and the 8 newest entries still pop in order.
- R8: A return on an empty stack loads the value most recently popped (000h if nothing has been popped since reset) and leaves the stack empty.
- R9: Priority is return, then call, then jump, then low-byte write, then step. With no strobe high, `pc_o` holds.
- R10: Page value 0, 1, 2 and 3 selects base 000h, 200h, 400h and 600h for jump and call targets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Advance to the next sequential address |
| jump_i | input | 1 | Load page and target |
| call_i | input | 1 | Load page and target, and save the return address |
| ret_i | input | 1 | Restore the saved return address |
| low_wr_i | input | 1 | Overwrite the address low byte |
| low_wdata_i | input | 8 | New low byte |
| page_i | input | 2 | Page-select bits |
| target_i | input | 9 | In-page target from the instruction |
| pc_o | output | 11 | Current fetch address |
| low_rdata_o | output | 8 | Address low byte as a readable register |

## Verification
The bench builds the unit with its default parameters: an 11-bit address, a 9-bit target, an 8-bit low byte and a stack depth of 8. With these values the 7FFh-to-000h wrap is reached in one step from the reset vector. A run of nine nested calls is short enough to fill the stack past its capacity, drain it completely, and then pop once more from the empty stack. The vector table also drives several strobes at once, so the priority order can be seen on `pc_o`.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [2:0] {
    NXT_HOLD,
    NXT_STEP,
    NXT_LOW,
    NXT_JUMP,
    NXT_POP
  } nxt_sel_e;
endpackage

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
  parameter int W     = 11,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_val,
  output logic [W-1:0] top_val
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(DEPTH);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] head;
  logic [CNT_W-1:0] count;
  logic [W-1:0]     last_pop;
  logic [PTR_W-1:0] below;

  // Slot just below the head, with wrap for any depth.
  assign below   = (head == '0) ? LAST_IDX : head - PTR_W'(1);
  assign top_val = (count != '0) ? slots[below] : last_pop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head     <= '0;
      count    <= '0;
      last_pop <= '0;
    end else if (push) begin
      // Circular write: once full, the oldest slot is overwritten.
      slots[head] <= push_val;
      head        <= (head == LAST_IDX) ? '0 : head + PTR_W'(1);
      if (count != FULL) count <= count + CNT_W'(1);
    end else if (pop) begin
      last_pop <= top_val;
      if (count != '0) begin
        head  <= below;
        count <= count - CNT_W'(1);
      end
    end
  end

  p_count_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);
  p_push_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && count != FULL) |=> count == $past(count) + CNT_W'(1));
  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && count == '0) |=> (count == '0 && head == $past(head)));
endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
  import pc_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int TGT_W  = 9,
  parameter int LOW_W  = 8
) (
  input  logic                 step,
  input  logic                 jump,
  input  logic                 call,
  input  logic                 ret,
  input  logic                 low_wr,
  input  logic [LOW_W-1:0]     low_wdata,
  input  logic [ADDR_W-TGT_W-1:0] page,
  input  logic [TGT_W-1:0]     target,
  input  logic [ADDR_W-1:0]    pc,
  input  logic [ADDR_W-1:0]    pop_val,
  output logic [ADDR_W-1:0]    nxt,
  output logic [ADDR_W-1:0]    ret_addr,
  output logic                 push,
  output logic                 pop
);
  localparam int HI_W = ADDR_W - LOW_W;

  nxt_sel_e sel;

  assign ret_addr = pc + ADDR_W'(1);
  assign pop      = ret;
  assign push     = call && !ret;

  always_comb begin
    if (ret)                 sel = NXT_POP;
    else if (call || jump)   sel = NXT_JUMP;
    else if (low_wr)         sel = NXT_LOW;
    else if (step)           sel = NXT_STEP;
    else                     sel = NXT_HOLD;
  end

  always_comb begin
    case (sel)
      NXT_POP:  nxt = pop_val;
      NXT_JUMP: nxt = {page, target};
      NXT_LOW:  nxt = {pc[ADDR_W-1 -: HI_W], low_wdata};
      NXT_STEP: nxt = ret_addr;
      default:  nxt = pc;
    endcase
  end
endmodule

// File: rtl/pc_unit.sv
module pc_unit #(
  parameter int ADDR_W = 11,
  parameter int TGT_W  = 9,
  parameter int LOW_W  = 8,
  parameter int DEPTH  = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = '1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_i,
  input  logic                    jump_i,
  input  logic                    call_i,
  input  logic                    ret_i,
  input  logic                    low_wr_i,
  input  logic [LOW_W-1:0]        low_wdata_i,
  input  logic [ADDR_W-TGT_W-1:0] page_i,
  input  logic [TGT_W-1:0]        target_i,
  output logic [ADDR_W-1:0]       pc_o,
  output logic [LOW_W-1:0]        low_rdata_o
);
  localparam int PAGE_W = ADDR_W - TGT_W;
  localparam int HI_W   = ADDR_W - LOW_W;

  logic [ADDR_W-1:0] pc_q, nxt, ret_addr, top_val;
  logic              push, pop;

  pc_next_sel #(.ADDR_W(ADDR_W), .TGT_W(TGT_W), .LOW_W(LOW_W)) u_sel (
    .step(step_i), .jump(jump_i), .call(call_i), .ret(ret_i),
    .low_wr(low_wr_i), .low_wdata(low_wdata_i), .page(page_i),
    .target(target_i), .pc(pc_q), .pop_val(top_val), .nxt(nxt),
    .ret_addr(ret_addr), .push(push), .pop(pop)
  );

  pc_ret_stack #(.W(ADDR_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .push_val(ret_addr), .top_val(top_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= nxt;
  end

  assign pc_o        = pc_q;
  assign low_rdata_o = pc_q[LOW_W-1:0];

  p_reset_vec_r1: assert property (@(posedge clk)
    !rst_n |=> pc_o == RESET_PC);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !jump_i && !call_i && !ret_i && !low_wr_i)
      |=> pc_o == ADDR_W'($past(pc_o) + ADDR_W'(1)));
  p_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((jump_i || call_i) && !ret_i)
      |=> pc_o[ADDR_W-1 -: PAGE_W] == $past(page_i));
  p_low_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (low_wr_i && !jump_i && !call_i && !ret_i)
      |=> (pc_o[ADDR_W-1 -: HI_W] == $past(pc_o[ADDR_W-1 -: HI_W])
           && low_rdata_o == $past(low_wdata_i)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !jump_i && !call_i && !ret_i && !low_wr_i) |=> $stable(pc_o));
endmodule

// File: tb/pc_unit_tb.sv
module pc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_i, jump_i, call_i, ret_i, low_wr_i;
  logic [7:0]  low_wdata_i;
  logic [1:0]  page_i;
  logic [8:0]  target_i;
  logic [10:0] pc_o;
  logic [7:0]  low_rdata_o;

  int checks = 0;
  int fails  = 0;
  logic [10:0] pushed [9];

  always #4 clk = ~clk;  // 125 MHz

  pc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .jump_i(jump_i),
    .call_i(call_i), .ret_i(ret_i), .low_wr_i(low_wr_i),
    .low_wdata_i(low_wdata_i), .page_i(page_i), .target_i(target_i),
    .pc_o(pc_o), .low_rdata_o(low_rdata_o)
  );

  // Vector: ctrl {ret,call,jump,low_wr,step}, page, target, wdata, expected pc, req
  typedef struct packed {
    logic [4:0]  ctrl;
    logic [1:0]  page;
    logic [8:0]  tgt;
    logic [7:0]  wd;
    logic [10:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{5'b00001, 2'd0, 9'h000, 8'h00, 11'h000, 4'd2},   // wrap 7FF->000
    '{5'b00001, 2'd0, 9'h000, 8'h00, 11'h001, 4'd2},
    '{5'b00100, 2'd1, 9'h034, 8'h00, 11'h234, 4'd10},  // page 1
    '{5'b01000, 2'd2, 9'h100, 8'h00, 11'h500, 4'd4},   // push 235
    '{5'b01000, 2'd3, 9'h1FF, 8'h00, 11'h7FF, 4'd4},   // push 501
    '{5'b00001, 2'd0, 9'h000, 8'h00, 11'h000, 4'd2},
    '{5'b10000, 2'd0, 9'h000, 8'h00, 11'h501, 4'd5},
    '{5'b00010, 2'd0, 9'h000, 8'h80, 11'h580, 4'd6},
    '{5'b10000, 2'd0, 9'h000, 8'h00, 11'h235, 4'd5},
    '{5'b00100, 2'd0, 9'h0AA, 8'h00, 11'h0AA, 4'd3},   // page 0
    '{5'b00000, 2'd0, 9'h000, 8'h00, 11'h0AA, 4'd9},   // hold
    '{5'b11100, 2'd1, 9'h011, 8'h00, 11'h235, 4'd8},   // empty pop wins
    '{5'b01100, 2'd0, 9'h010, 8'h00, 11'h010, 4'd9},   // call over jump, push 236
    '{5'b10000, 2'd0, 9'h000, 8'h00, 11'h236, 4'd4},
    '{5'b00110, 2'd1, 9'h005, 8'h22, 11'h205, 4'd9},   // jump over low write
    '{5'b00011, 2'd0, 9'h000, 8'h40, 11'h240, 4'd9}    // low write over step
  };

  function automatic string req_name(input int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] c, input logic [1:0] pg,
                       input logic [8:0] t, input logic [7:0] wd);
    {ret_i, call_i, jump_i, low_wr_i, step_i} = c;
    page_i = pg; target_i = t; low_wdata_i = wd;
    @(negedge clk);
    {ret_i, call_i, jump_i, low_wr_i, step_i} = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {ret_i, call_i, jump_i, low_wr_i, step_i} = '0;
    page_i = '0; target_i = '0; low_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset vector and read-back of the low byte
    check("R1", pc_o, 11'h7FF);
    check("R6", {3'b000, low_rdata_o}, 11'h0FF);
    // R8: return right after reset finds an empty stack and yields 000h
    drive(5'b10000, 2'd0, 9'h0, 8'h0);
    check("R8", pc_o, 11'h000);

    do_reset();
    for (int i = 0; i < 16; i++) begin
      drive(VECS[i].ctrl, VECS[i].page, VECS[i].tgt, VECS[i].wd);
      check(req_name(int'(VECS[i].req)), pc_o, VECS[i].exp);
      check("R6", {3'b000, low_rdata_o}, {3'b000, pc_o[7:0]});
    end

    // R7: nine nested calls, the oldest return address is lost
    do_reset();
    for (int i = 0; i < 9; i++) begin
      pushed[i] = pc_o + 11'd1;
      drive(5'b01000, 2'd0, 9'(i * 16), 8'h0);
      check("R4", pc_o, 11'(i * 16));
    end
    for (int i = 8; i >= 1; i--) begin
      drive(5'b10000, 2'd0, 9'h0, 8'h0);
      check("R7", pc_o, pushed[i]);
    end
    // R8: the stack is now empty, so the last popped value returns again
    drive(5'b10000, 2'd0, 9'h0, 8'h0);
    check("R8", pc_o, pushed[1]);
    drive(5'b10000, 2'd0, 9'h0, 8'h0);
    check("R8", pc_o, pushed[1]);

    // R10: base address of every page
    for (int p = 0; p < 4; p++) begin
      drive(5'b00100, 2'(p), 9'h000, 8'h0);
      check("R10", pc_o, 11'(p * 512));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule